// File: doc/BRIEF.md
# Peripheral rate-control flow gate

The gate sits between a set of peripheral request lines and a data mover. It paces the mover so that data moves only as fast as each peripheral asks for it. Every request line has its own small control register with three fields: a reset flag, an input-select flag and a block-size code. A rising edge on a line's selected request input opens one credit. While the credit is open the mover may move exactly one block of bytes. After that the line waits for the next rising edge before it grants again.

The mover presents the flow-control fields of its current command. One 4-bit field names the source-side line and another names the destination-side line. A field value of 0 means that side is not paced. The gate drives one grant level. The mover pulses an acknowledge for every beat it moves while the grant is high. A beat is `BEAT_BYTES` bytes, and the gate counts beats against the block size of every line the command names. Address generation and the data path stay in the mover.

Top module: `rate_gate`

## Requirements
- R1: After `rst_n` every line comes up with its reset flag set (control bit 17 = 1) and no credit, so any command naming a nonzero line sees the grant low, even when that line's request pulses.
- R2: The command's source-side line number sits in bits 6:3 and the destination-side line number in bits 10:7; the port carries bits 10:3, and nothing outside the two fields changes the grant.
- R3: `mv_grant` is high only while `cmd_active` is high and each of the two sides is satisfied. A side is satisfied when its field is 0, or when the line it names holds an open credit and is out of reset. When only one side holds a credit the grant stays low.
- R4: A command whose two fields are both 0 sees the grant held high for as long as `cmd_active` is high.
- R5: With `cmd_active` low the grant is low, and acknowledges are not counted.
- R6: A rising edge of a line's selected request input, sampled at a clock edge, opens the credit at that edge; the grant reflects it combinationally right after that edge, and not before.
- R7: Block-size code c in control bits 2:0 sets a block of 16<<c bytes, which is (16<<c)/BEAT_BYTES beats (at least one). The credit closes at the clock edge that accepts the last beat of the block.
- R8: One rising edge gives one block. A request held high, or a rising edge while a credit is already open, adds nothing. A rising edge in the same cycle as the last beat reopens the credit with a fresh count.
- R9: Control bit 18 selects the alternate request input of the line when 1, and the main input when 0. Edges on the input that is not selected are ignored.
- R10: While a line's reset flag is set, its request edges are dropped and its credit and beat count are cleared, starting with the write that sets the flag. Clearing the flag again does not restore a credit.
- R11: An acknowledge is counted only while the grant is high. A line named by both fields counts each beat once.
- R12: A write with `cfg_we` high and `cfg_line` in 1..15 replaces that line's flags and code at the clock edge; a changed code sets the size of the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_line | input | 4 | Line number written (1..15) |
| cfg_flags | input | 2 | Control word bits 18:17 (bit 18 input select, bit 17 line reset) |
| cfg_code | input | 3 | Control word bits 2:0, block-size code |
| req_main | input | 15 | Main request input of lines 1..15 (bit n-1 = line n) |
| req_alt | input | 15 | Alternate request input of lines 1..15 |
| cmd_active | input | 1 | Mover has a command in progress |
| cmd_fields | input | 8 | Command word bits 10:3 (destination line 10:7, source line 6:3) |
| mv_ack | input | 1 | Mover moved one beat this cycle |
| mv_grant | output | 1 | Mover may move data |

## Verification
A wrong credit bit shows at `mv_grant` right after the clock edge that stored it, as long as the command names that line. A wrong beat count stays hidden until the block should end, so the grant closes one or more beats early or late. The bench drives blocks with more than one beat and checks the grant after the next-to-last and after the last acknowledge. A wrong select or reset flag is silent until the next request edge, and so every such case is followed by a pulse and a probe of the grant.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int FIELD_W    = 4;
  localparam int SRC_LSB    = 3;
  localparam int DST_LSB    = 7;
  localparam int CMD_MSB    = DST_LSB + FIELD_W - 1;
  localparam int RST_BIT    = 17;
  localparam int MUX_BIT    = 18;
  localparam int CODE_W     = 3;
  localparam int BASE_BYTES = 16;

  // Source-side line number from command bits 10:3 as carried on the port.
  function automatic logic [FIELD_W-1:0] src_of(input logic [CMD_MSB:SRC_LSB] f);
    return f[SRC_LSB +: FIELD_W];
  endfunction

  function automatic logic [FIELD_W-1:0] dst_of(input logic [CMD_MSB:SRC_LSB] f);
    return f[DST_LSB +: FIELD_W];
  endfunction

  // Beats needed for one block of the given code.
  function automatic int unsigned beats_per_block(input logic [CODE_W-1:0] code,
                                                  input int unsigned beat_bytes);
    int unsigned bytes;
    bytes = BASE_BYTES << code;
    if (bytes <= beat_bytes) return 1;
    return bytes / beat_bytes;
  endfunction
endpackage

// File: rtl/rg_line_slot.sv
module rg_line_slot import rg_pkg::*; #(
  parameter int BEAT_BYTES = 4,
  parameter int CNT_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_rst,
  input  logic              wr_mux,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              req_main,
  input  logic              req_alt,
  input  logic              named,
  input  logic              take,
  output logic              credit,
  output logic              held,
  output logic              rise,
  output logic              last
);
  logic              rst_q, mux_q, prev_q, pend_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  need;
  logic              sel, hit, clear;

  assign sel   = mux_q ? req_alt : req_main;
  assign rise  = sel & ~prev_q & ~rst_q;
  assign need  = CNT_W'(beats_per_block(code_q, BEAT_BYTES));
  assign hit   = take & named & pend_q;
  assign last  = hit & (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, need});
  assign clear = rst_q | (wr_en & wr_rst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      mux_q  <= 1'b0;
      code_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sel;
      if (wr_en) begin
        rst_q  <= wr_rst;
        mux_q  <= wr_mux;
        code_q <= wr_code;
      end
      if (clear) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        pend_q <= (pend_q & ~last) | rise;
        if (hit) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign credit = pend_q;
  assign held   = rst_q;
endmodule

// File: rtl/rg_cmd_decode.sv
module rg_cmd_decode import rg_pkg::*; #(
  parameter int N = 15
) (
  input  logic               cmd_active,
  input  logic [FIELD_W-1:0] src_sel,
  input  logic [FIELD_W-1:0] dst_sel,
  input  logic [N-1:0]       credit,
  input  logic [N-1:0]       held,
  output logic               src_ok,
  output logic               dst_ok,
  output logic               grant,
  output logic [N-1:0]       named
);
  function automatic logic side_ok(input logic [FIELD_W-1:0] f,
                                   input logic [N-1:0] cr,
                                   input logic [N-1:0] hd);
    if (f == '0) return 1'b1;
    if (int'(f) > N) return 1'b0;
    return cr[int'(f)-1] & ~hd[int'(f)-1];
  endfunction

  always_comb begin
    src_ok = side_ok(src_sel, credit, held);
    dst_ok = side_ok(dst_sel, credit, held);
    grant  = cmd_active & src_ok & dst_ok;
    for (int i = 0; i < N; i++) begin
      named[i] = cmd_active & ((int'(src_sel) == i + 1) | (int'(dst_sel) == i + 1));
    end
  end
endmodule

// File: rtl/rate_gate.sv
module rate_gate import rg_pkg::*; #(
  parameter int N_LINES    = 15,
  parameter int BEAT_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [FIELD_W-1:0]     cfg_line,
  input  logic [MUX_BIT:RST_BIT] cfg_flags,
  input  logic [CODE_W-1:0]      cfg_code,
  input  logic [N_LINES-1:0]     req_main,
  input  logic [N_LINES-1:0]     req_alt,
  input  logic                   cmd_active,
  input  logic [CMD_MSB:SRC_LSB] cmd_fields,
  input  logic                   mv_ack,
  output logic                   mv_grant
);
  localparam int MAX_BEATS = (BASE_BYTES << ((1 << CODE_W) - 1)) / BEAT_BYTES;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  logic [FIELD_W-1:0] src_sel, dst_sel;
  logic [N_LINES-1:0] line_credit, line_held, line_rise, line_last, line_named;
  logic               src_ok, dst_ok, grant, take;

  assign src_sel = src_of(cmd_fields);
  assign dst_sel = dst_of(cmd_fields);
  assign take    = mv_ack & grant;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    logic wr_en;
    assign wr_en = cfg_we & (int'(cfg_line) == i + 1);
    rg_line_slot #(.BEAT_BYTES(BEAT_BYTES), .CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_rst   (cfg_flags[RST_BIT]),
      .wr_mux   (cfg_flags[MUX_BIT]),
      .wr_code  (cfg_code),
      .req_main (req_main[i]),
      .req_alt  (req_alt[i]),
      .named    (line_named[i]),
      .take     (take),
      .credit   (line_credit[i]),
      .held     (line_held[i]),
      .rise     (line_rise[i]),
      .last     (line_last[i])
    );
  end

  rg_cmd_decode #(.N(N_LINES)) u_dec (
    .cmd_active (cmd_active),
    .src_sel    (src_sel),
    .dst_sel    (dst_sel),
    .credit     (line_credit),
    .held       (line_held),
    .src_ok     (src_ok),
    .dst_ok     (dst_ok),
    .grant      (grant),
    .named      (line_named)
  );

  assign mv_grant = grant;
endmodule

// File: rtl/rg_gate_chk.sv
module rg_gate_chk import rg_pkg::*; #(
  parameter int N = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_active,
  input logic [FIELD_W-1:0] src_sel,
  input logic [FIELD_W-1:0] dst_sel,
  input logic               mv_grant,
  input logic [N-1:0]       line_credit,
  input logic [N-1:0]       line_held,
  input logic [N-1:0]       line_rise,
  input logic [N-1:0]       line_last
);
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_active |-> !mv_grant); // R5

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_active && src_sel == '0 && dst_sel == '0) |-> mv_grant); // R4

  AST_HELD_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_credit & line_held) == '0); // R10

  AST_SRC_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_grant && src_sel != '0 && int'(src_sel) <= N) |-> line_credit[int'(src_sel)-1]); // R3

  AST_DST_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_grant && dst_sel != '0 && int'(dst_sel) <= N) |-> line_credit[int'(dst_sel)-1]); // R3

  for (genvar i = 0; i < N; i++) begin : g_line_chk
    AST_CREDIT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_credit[i]) |-> $past(line_rise[i])); // R6

    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (line_last[i] && !line_rise[i]) |=> !line_credit[i]); // R7
  end
endmodule

bind rate_gate rg_gate_chk #(.N(N_LINES)) u_gate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_active  (cmd_active),
  .src_sel     (src_sel),
  .dst_sel     (dst_sel),
  .mv_grant    (mv_grant),
  .line_credit (line_credit),
  .line_held   (line_held),
  .line_rise   (line_rise),
  .line_last   (line_last)
);

// File: tb/test_rate_gate.sv
module test_rate_gate;
  localparam int N  = 15;
  localparam int BB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_line = '0;
  logic [18:17]  cfg_flags = '0;
  logic [2:0]    cfg_code = '0;
  logic [N-1:0]  req_main = '0;
  logic [N-1:0]  req_alt = '0;
  logic          cmd_active = 1'b0;
  logic [31:0]   cmd = '0;
  logic [10:3]   cmd_fields;
  logic          mv_ack = 1'b0;
  logic          mv_grant;

  assign cmd_fields = cmd[10:3];

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rate_gate i_rate_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .cfg_flags(cfg_flags), .cfg_code(cfg_code), .req_main(req_main),
    .req_alt(req_alt), .cmd_active(cmd_active), .cmd_fields(cmd_fields),
    .mv_ack(mv_ack), .mv_grant(mv_grant)
  );

  // Behavioural reference: per-line flags, credit and beat count.
  int m_rst[16], m_mux[16], m_code[16], m_pend[16], m_cnt[16], m_prev[16];

  function automatic int fsrc(); return int'(cmd[6:3]); endfunction
  function automatic int fdst(); return int'(cmd[10:7]); endfunction

  function automatic bit side(input int f);
    if (f == 0) return 1;
    return (m_rst[f] == 0) && (m_pend[f] != 0);
  endfunction

  function automatic bit model_grant();
    return cmd_active && side(fsrc()) && side(fdst());
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 1; n <= N; n++) begin
        m_rst[n] = 1; m_mux[n] = 0; m_code[n] = 0;
        m_pend[n] = 0; m_cnt[n] = 0; m_prev[n] = 0;
      end
    end else begin
      bit g;
      g = model_grant();
      for (int n = 1; n <= N; n++) begin
        int sel, rise, named, take, need, fin, wr;
        sel   = m_mux[n] ? int'(req_alt[n-1]) : int'(req_main[n-1]);
        rise  = (sel == 1 && m_prev[n] == 0);
        named = cmd_active && (fsrc() == n || fdst() == n);
        take  = mv_ack && g && named;
        need  = (16 << m_code[n]) / BB;
        if (need < 1) need = 1;
        fin   = take && (m_cnt[n] + 1 >= need);
        wr    = cfg_we && int'(cfg_line) == n;
        if (m_rst[n] != 0 || (wr && cfg_flags[17])) begin
          m_pend[n] = 0; m_cnt[n] = 0;
        end else begin
          m_pend[n] = ((m_pend[n] != 0) && !fin) || (rise != 0);
          if (take) m_cnt[n] = fin ? 0 : m_cnt[n] + 1;
        end
        m_prev[n] = sel;
        if (wr) begin
          m_rst[n] = cfg_flags[17]; m_mux[n] = cfg_flags[18]; m_code[n] = int'(cfg_code);
        end
      end
    end
    #5;
    if (rst_n) begin
      checks++;
      if (mv_grant !== model_grant()) begin
        errors++;
        $display("FAIL R3 cycle compare t=%0t: mv_grant=%b expected=%b", $time, mv_grant, model_grant());
      end
    end
  end

  task automatic probe(input bit exp, input string tag);
    #1;
    checks++;
    if (mv_grant !== exp) begin
      errors++;
      $display("FAIL %s: mv_grant=%b expected=%b", tag, mv_grant, exp);
    end
  endtask

  task automatic cfg(input int line, input bit r, input bit m, input int code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_line = 4'(line);
    cfg_flags = {m, r}; cfg_code = 3'(code);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int line, input bit alt);
    @(negedge clk);
    if (alt) req_alt[line-1] = 1'b1; else req_main[line-1] = 1'b1;
    @(negedge clk);
    if (alt) req_alt[line-1] = 1'b0; else req_main[line-1] = 1'b0;
  endtask

  task automatic acks(input int n);
    @(negedge clk);
    mv_ack = 1'b1;
    repeat (n) @(negedge clk);
    mv_ack = 1'b0;
  endtask

  task automatic set_cmd(input bit act, input int s, input int d, input logic [31:0] junk);
    @(negedge clk);
    cmd_active = act;
    cmd = junk & ~32'h0000_07F8;
    cmd[6:3]  = 4'(s);
    cmd[10:7] = 4'(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: lines start in reset
    set_cmd(1, 1, 0, 0);
    probe(0, "R1 grant after reset");
    pulse(1, 0);
    probe(0, "R1 request on unreleased line");
    // R4 / R2: both fields zero, other bits set
    set_cmd(1, 0, 0, 32'hFFFF_F807);
    probe(1, "R4 R2 line 0 passthrough with foreign bits");
    // R5
    set_cmd(0, 0, 0, 0);
    probe(0, "R5 inactive command");
    // R6 R7 R8 on line 2, code 0 = 4 beats
    cfg(2, 0, 0, 0);
    set_cmd(1, 2, 0, 0);
    @(negedge clk); req_main[1] = 1'b1;
    probe(0, "R6 grant before sampling edge");
    @(negedge clk);
    probe(1, "R6 grant after sampling edge");
    acks(3);
    probe(1, "R7 open after 3 of 4 beats");
    acks(1);
    probe(0, "R7 closed after 4 beats");
    repeat (3) @(negedge clk);
    probe(0, "R8 held request gives no second block");
    req_main[1] = 1'b0;
    pulse(2, 0);
    probe(1, "R8 new edge reopens");
    acks(4);
    probe(0, "R7 second block closed");
    // R7 code 2 on destination side, line 3: 16 beats
    cfg(3, 0, 0, 2);
    set_cmd(1, 0, 3, 0);
    pulse(3, 0);
    acks(15);
    probe(1, "R7 code 2 open after 15 beats");
    acks(1);
    probe(0, "R7 code 2 closed after 16 beats");
    // R11 acks without grant ignored
    acks(5);
    pulse(3, 0);
    acks(15);
    probe(1, "R11 earlier ungranted acks not counted");
    acks(1);
    probe(0, "R11 block closes on its own 16th beat");
    // R9 input select
    cfg(4, 0, 1, 0);
    set_cmd(1, 4, 0, 0);
    pulse(4, 0);
    probe(0, "R9 main input ignored when alternate selected");
    pulse(4, 1);
    probe(1, "R9 alternate input opens credit");
    acks(4);
    probe(0, "R9 block done");
    // R10 reset mid block
    pulse(4, 1);
    acks(2);
    cfg(4, 1, 1, 0);
    probe(0, "R10 reset flag drops credit");
    pulse(4, 1);
    probe(0, "R10 edge dropped while held");
    cfg(4, 0, 1, 0);
    probe(0, "R10 release does not restore credit");
    pulse(4, 1);
    acks(3);
    probe(1, "R10 count restarted after reset");
    acks(1);
    probe(0, "R10 full block after reset");
    // R3 both sides
    cfg(5, 0, 0, 0);
    set_cmd(1, 2, 5, 0);
    pulse(2, 0);
    probe(0, "R3 only source credit");
    pulse(5, 0);
    probe(1, "R3 both credits");
    acks(4);
    probe(0, "R3 both blocks consumed");
    // R11 same line on both sides
    set_cmd(1, 2, 2, 0);
    pulse(2, 0);
    acks(3);
    probe(1, "R11 shared line counts once per beat");
    acks(1);
    probe(0, "R11 shared line closes on 4th beat");
    // R8 edge together with last beat
    pulse(2, 0);
    acks(3);
    @(negedge clk); mv_ack = 1'b1; req_main[1] = 1'b1;
    @(negedge clk); mv_ack = 1'b0; req_main[1] = 1'b0;
    probe(1, "R8 edge on last beat reopens");
    acks(4);
    probe(0, "R8 reopened block closes");
    // R8 edge while open absorbed
    pulse(2, 0);
    acks(1);
    pulse(2, 0);
    acks(3);
    probe(0, "R8 edge during open block absorbed");
    // R12 rewrite code 1 = 8 beats
    cfg(2, 0, 0, 1);
    pulse(2, 0);
    acks(7);
    probe(1, "R12 new code open after 7 beats");
    acks(1);
    probe(0, "R12 new code closed after 8 beats");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule